// File: doc/BRIEF.md
# Protection Region Configuration Register Bank

This block holds the configuration of a small memory protection unit with eight regions. A word-wide write/read port reaches a region selector, a region base register and a region attribute/size register. The base and attribute registers are windows onto whichever region the selector names. A base write can carry its own region number and a flag that asks for that number to be used. In that case the write moves the selector and stores the base into the newly named region in the same cycle.

Three extra base/attribute address pairs behave exactly like the primary pair. A single multi-word burst can therefore program up to four regions back to back. A burst of three words starting at the selector selects a region, then writes its base, then writes its attributes.

The block drives the stored settings of every region on flat output vectors: the base address (masked to the region size), the size code, the enable, the eight subregion-disable bits and the sixteen attribute bits. Address matching, faults and privilege checks belong to other blocks.

Top module: `mpu_cfg_bank`

## Requirements
- R1: After synchronous reset the selector reads 0 and every region output (base, size, enable, subregion mask, attributes) is zero.
- R2: A write to byte offset 0x00 with a value below 8 sets the selector, and a read of 0x00 returns it in bits 2:0. A write of 8 or more is ignored and leaves the selector unchanged.
- R3: A write to a base offset with bit 4 clear stores bits 31:5 into the currently selected region and leaves the selector unchanged.
- R4: A write to a base offset with bit 4 set and bits 3:0 below 8 sets the selector to bits 2:0 and stores bits 31:5 into that region. If bits 3:0 are 8 or more, the write is ignored completely.
- R5: A write to an attribute offset stores enable from bit 0, size code from bits 5:1, subregion-disable mask from bits 15:8 and attributes from bits 31:16 into the selected region. A read returns the same fields in the same positions, with bits 7:6 as zero. A read-modify-write that clears bit 0 disables the region and keeps its other fields.
- R6: The base seen on the outputs and on reads has every bit below position max(5, size+1) forced to zero, and the stored upper bits are kept for later size changes. A base read also returns the selector in bits 2:0, with bits 4:3 as zero.
- R7: The pairs at byte offsets 0x0C/0x10, 0x14/0x18 and 0x1C/0x20 act exactly as the base/attribute pair at 0x04/0x08, for both reads and writes.
- R8: A read request gives rvalid and rdata on the next cycle. Offsets above 0x20 read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request, one word per cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 6 | Byte address; bits 1:0 ignored |
| wdata | input | 32 | Write data |
| rvalid | output | 1 | Read data valid, one cycle after a read request |
| rdata | output | 32 | Read data |
| region_base | output | 256 | Masked base address per region, region i at bits 32i+31:32i |
| region_size | output | 40 | Size code per region, 5 bits each |
| region_en | output | 8 | Enable per region |
| region_srd | output | 64 | Subregion-disable mask per region, 8 bits each |
| region_attr | output | 128 | Attribute bits per region, 16 bits each |

## Verification
A wrong selector is the most damaging internal fault. The next base or attribute write then lands in a different region, and the change shows on that region's output vectors in the cycle after the write. A base or attribute read also returns another region's contents at the next rvalid. A stray write enable to a region shows up as a change on an output slice that should have held still. A wrong size mask shows as low base bits that are set, or that vanish, on the same cycle the size code changes.

// File: rtl/mpu_cfg_pkg.sv
package mpu_cfg_pkg;

    localparam int DATA_W      = 32;
    localparam int BASE_FLOOR  = 5;
    localparam int SIZE_W      = 5;
    localparam int SRD_W       = 8;
    localparam int ATTR_W      = 16;
    localparam int SEL_FLAG    = 4;
    localparam int NUM_FIELD_W = 4;
    localparam int LAST_WORD   = 8;

    typedef enum logic [1:0] {
        ACC_SEL  = 2'd0,
        ACC_BASE = 2'd1,
        ACC_ATTR = 2'd2,
        ACC_NONE = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic [DATA_W-1:BASE_FLOOR] base_hi;
        logic [ATTR_W-1:0]          attr;
        logic [SRD_W-1:0]           srd;
        logic [SIZE_W-1:0]          size;
        logic                       en;
    } region_t;

    function automatic acc_kind_e decode_word(input int unsigned idx);
        acc_kind_e k;
        if (idx == 0)
            k = ACC_SEL;
        else if (idx <= LAST_WORD)
            k = (idx % 2 == 1) ? ACC_BASE : ACC_ATTR;
        else
            k = ACC_NONE;
        return k;
    endfunction

    function automatic logic [DATA_W-1:0] base_mask(input logic [SIZE_W-1:0] size);
        int lsb;
        logic [DATA_W-1:0] m;
        lsb = int'(size) + 1;
        if (lsb < BASE_FLOOR)
            lsb = BASE_FLOOR;
        m = '1;
        if (lsb >= DATA_W)
            m = '0;
        else
            m = m << lsb;
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] pack_attr(input region_t r);
        return {r.attr, r.srd, 2'b00, r.size, r.en};
    endfunction

endpackage

// File: rtl/mpu_cfg_decode.sv
module mpu_cfg_decode
    import mpu_cfg_pkg::*;
#(
    parameter int NREG = 8,
    parameter int AW   = 6,
    localparam int RNW = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic              req,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [RNW-1:0]    sel_q,
    output acc_kind_e         kind,
    output logic              rd_req,
    output logic              wr_sel,
    output logic [RNW-1:0]    next_sel,
    output logic              wr_base,
    output logic              wr_attr,
    output logic [RNW-1:0]    target
);

    logic [31:0] word_idx;
    logic        num_ok;
    logic        sel_ok;
    logic        flag;
    logic        wr;
    logic [1:0]  unused_byte_lanes;

    assign unused_byte_lanes = addr[1:0];
    assign word_idx = {{(32-(AW-2)){1'b0}}, addr[AW-1:2]};

    always_comb begin
        kind     = decode_word(word_idx);
        wr       = req && we;
        rd_req   = req && !we;
        flag     = wdata[SEL_FLAG];
        num_ok   = {{(32-NUM_FIELD_W){1'b0}}, wdata[NUM_FIELD_W-1:0]} < 32'(NREG);
        sel_ok   = wdata < 32'(NREG);
        next_sel = wdata[RNW-1:0];
        wr_sel   = wr && (((kind == ACC_SEL) && sel_ok) ||
                          ((kind == ACC_BASE) && flag && num_ok));
        wr_base  = wr && (kind == ACC_BASE) && (!flag || num_ok);
        wr_attr  = wr && (kind == ACC_ATTR);
        target   = ((kind == ACC_BASE) && flag) ? next_sel : sel_q;
    end

endmodule

// File: rtl/mpu_cfg_region.sv
module mpu_cfg_region
    import mpu_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              base_we,
    input  logic              attr_we,
    input  logic [DATA_W-1:0] wdata,
    output region_t           q,
    output logic [DATA_W-1:0] base_eff
);

    region_t    r_q;
    logic [6:0] unused_low_bits;

    assign unused_low_bits = {wdata[7:6], wdata[BASE_FLOOR-1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            if (base_we)
                r_q.base_hi <= wdata[DATA_W-1:BASE_FLOOR];
            if (attr_we) begin
                r_q.en   <= wdata[0];
                r_q.size <= wdata[SIZE_W:1];
                r_q.srd  <= wdata[8 +: SRD_W];
                r_q.attr <= wdata[16 +: ATTR_W];
            end
        end
    end

    assign q        = r_q;
    assign base_eff = {r_q.base_hi, {BASE_FLOOR{1'b0}}} & base_mask(r_q.size);

endmodule

// File: rtl/mpu_cfg_bank.sv
module mpu_cfg_bank
    import mpu_cfg_pkg::*;
#(
    parameter int NREG = 8,
    parameter int AW   = 6
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req,
    input  logic                     we,
    input  logic [AW-1:0]            addr,
    input  logic [31:0]              wdata,
    output logic                     rvalid,
    output logic [31:0]              rdata,
    output logic [NREG*32-1:0]       region_base,
    output logic [NREG*SIZE_W-1:0]   region_size,
    output logic [NREG-1:0]          region_en,
    output logic [NREG*SRD_W-1:0]    region_srd,
    output logic [NREG*ATTR_W-1:0]   region_attr
);

    localparam int RNW = (NREG > 1) ? $clog2(NREG) : 1;

    acc_kind_e      kind;
    logic           rd_req;
    logic           wr_sel;
    logic [RNW-1:0] next_sel;
    logic           wr_base;
    logic           wr_attr;
    logic [RNW-1:0] target;
    logic [RNW-1:0] sel_q;

    region_t           rq   [NREG];
    logic [DATA_W-1:0] beff [NREG];
    logic [DATA_W-1:0] rd_mux;

    mpu_cfg_decode #(.NREG(NREG), .AW(AW)) u_dec (
        .req      (req),
        .we       (we),
        .addr     (addr),
        .wdata    (wdata),
        .sel_q    (sel_q),
        .kind     (kind),
        .rd_req   (rd_req),
        .wr_sel   (wr_sel),
        .next_sel (next_sel),
        .wr_base  (wr_base),
        .wr_attr  (wr_attr),
        .target   (target)
    );

    always_ff @(posedge clk) begin
        if (rst)
            sel_q <= '0;
        else if (wr_sel)
            sel_q <= next_sel;
    end

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        mpu_cfg_region u_region (
            .clk      (clk),
            .rst      (rst),
            .base_we  (wr_base && (target == RNW'(i))),
            .attr_we  (wr_attr && (target == RNW'(i))),
            .wdata    (wdata),
            .q        (rq[i]),
            .base_eff (beff[i])
        );
        assign region_base[i*32 +: 32]         = beff[i];
        assign region_size[i*SIZE_W +: SIZE_W] = rq[i].size;
        assign region_en[i]                    = rq[i].en;
        assign region_srd[i*SRD_W +: SRD_W]    = rq[i].srd;
        assign region_attr[i*ATTR_W +: ATTR_W] = rq[i].attr;
    end

    always_comb begin
        unique case (kind)
            ACC_SEL:  rd_mux = {{(DATA_W-RNW){1'b0}}, sel_q};
            ACC_BASE: rd_mux = beff[sel_q] | {{(DATA_W-RNW){1'b0}}, sel_q};
            ACC_ATTR: rd_mux = pack_attr(rq[sel_q]);
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= rd_req;
            if (rd_req)
                rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/mpu_cfg_checker.sv
module mpu_cfg_checker
    import mpu_cfg_pkg::*;
#(
    parameter int NREG = 8,
    parameter int AW   = 6,
    localparam int RNW = (NREG > 1) ? $clog2(NREG) : 1
) (
    input logic               clk,
    input logic               rst,
    input logic               req,
    input logic               we,
    input logic [AW-1:0]      addr,
    input logic [31:0]        wdata,
    input logic               rvalid,
    input logic [RNW-1:0]     sel_q,
    input logic [NREG-1:0]    region_en,
    input logic [NREG*32-1:0] region_base
);

    logic [31:0] c_idx;
    acc_kind_e   c_kind;
    logic        c_wr;
    logic [1:0]  unused_c_lanes;

    assign unused_c_lanes = addr[1:0];
    assign c_idx  = {{(32-(AW-2)){1'b0}}, addr[AW-1:2]};
    assign c_kind = decode_word(c_idx);
    assign c_wr   = req && we;

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (sel_q == '0) && (region_en == '0) && !rvalid);

    p_sel_reject_r2: assert property (@(posedge clk) disable iff (rst)
        (c_wr && (c_kind == ACC_SEL) && (wdata >= 32'(NREG))) |=> $stable(sel_q));

    p_plain_base_keeps_sel_r3: assert property (@(posedge clk) disable iff (rst)
        (c_wr && (c_kind == ACC_BASE) && !wdata[SEL_FLAG]) |=> $stable(sel_q));

    p_flag_base_moves_sel_r4: assert property (@(posedge clk) disable iff (rst)
        (c_wr && (c_kind == ACC_BASE) && wdata[SEL_FLAG] && !wdata[3])
        |=> (sel_q == $past(wdata[RNW-1:0])));

    p_attr_enable_r5: assert property (@(posedge clk) disable iff (rst)
        (c_wr && (c_kind == ACC_ATTR)) |=> (region_en[$past(sel_q)] == $past(wdata[0])));

    p_read_latency_r8: assert property (@(posedge clk) disable iff (rst)
        (req && !we) |=> rvalid);

    p_no_spurious_rvalid_r8: assert property (@(posedge clk) disable iff (rst)
        !(req && !we) |=> !rvalid);

    p_unmapped_inert_r8: assert property (@(posedge clk) disable iff (rst)
        (c_wr && (c_kind == ACC_NONE))
        |=> $stable(sel_q) && $stable(region_en) && $stable(region_base));

endmodule

bind mpu_cfg_bank mpu_cfg_checker #(.NREG(NREG), .AW(AW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req         (req),
    .we          (we),
    .addr        (addr),
    .wdata       (wdata),
    .rvalid      (rvalid),
    .sel_q       (sel_q),
    .region_en   (region_en),
    .region_base (region_base)
);

// File: tb/tb_mpu_cfg_bank.sv
module tb_mpu_cfg_bank;

    localparam int NREG = 8;
    localparam int AW   = 6;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                req = 1'b0;
    logic                we  = 1'b0;
    logic [AW-1:0]       addr = '0;
    logic [31:0]         wdata = '0;
    logic                rvalid;
    logic [31:0]         rdata;
    logic [NREG*32-1:0]  region_base;
    logic [NREG*5-1:0]   region_size;
    logic [NREG-1:0]     region_en;
    logic [NREG*8-1:0]   region_srd;
    logic [NREG*16-1:0]  region_attr;

    int checks = 0;
    int errors = 0;

    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #2 clk = ~clk;

    mpu_cfg_bank #(.NREG(NREG), .AW(AW)) dut (
        .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr), .wdata(wdata),
        .rvalid(rvalid), .rdata(rdata), .region_base(region_base),
        .region_size(region_size), .region_en(region_en),
        .region_srd(region_srd), .region_attr(region_attr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [31:0] d);
        req = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        req = 1'b1; we = 1'b0; addr = a;
        @(negedge clk);
        req = 1'b0;
    endtask

    // monitor: pops one expected item per returned read
    always @(negedge clk) begin
        if (!rst && rvalid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R8 actual=unexpected-rvalid expected=none");
            end else begin
                chk(tag_q.pop_front(), rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 en", {24'b0, region_en}, 32'h0);
        chk("R1 base3", region_base[3*32 +: 32], 32'h0);
        chk("R1 attr0", {16'b0, region_attr[0 +: 16]}, 32'h0);
        do_read(6'h00, 32'h0, "R1 sel read");

        // R2 selector
        do_write(6'h00, 32'd3);
        do_read(6'h00, 32'd3, "R2 sel=3");
        do_write(6'h00, 32'd9);
        do_read(6'h00, 32'd3, "R2 sel write 9 ignored");

        // R3 plain base write
        do_write(6'h04, 32'h2000_1200);
        chk("R3 base3 out", region_base[3*32 +: 32], 32'h2000_1200);
        do_read(6'h04, 32'h2000_1203, "R3 base read");
        do_read(6'h00, 32'd3, "R3 sel kept");

        // R5 attribute write, bits 7:6 dropped
        do_write(6'h08, 32'h1234_ABCB);
        do_read(6'h08, 32'h1234_AB0B, "R5 attr read");
        chk("R5 en3", {31'b0, region_en[3]}, 32'h1);
        chk("R5 size3", {27'b0, region_size[3*5 +: 5]}, 32'd5);
        chk("R5 srd3", {24'b0, region_srd[3*8 +: 8]}, 32'hAB);
        chk("R5 attr3", {16'b0, region_attr[3*16 +: 16]}, 32'h1234);

        // R6 size masking
        do_write(6'h04, 32'h2000_12E0);
        chk("R6 mask size5", region_base[3*32 +: 32], 32'h2000_12C0);
        do_read(6'h04, 32'h2000_12C3, "R6 base read size5");
        do_write(6'h08, 32'h0000_001F);
        chk("R6 mask size15", region_base[3*32 +: 32], 32'h2000_0000);
        do_read(6'h04, 32'h2000_0003, "R6 base read size15");
        do_write(6'h08, 32'h0000_003F);
        chk("R6 mask size31", region_base[3*32 +: 32], 32'h0);
        do_read(6'h04, 32'h0000_0003, "R6 base read size31");
        do_write(6'h08, 32'h0000_0001);
        chk("R6 upper bits kept", region_base[3*32 +: 32], 32'h2000_12E0);

        // R4 base write that selects
        do_write(6'h04, 32'h4000_0015);
        chk("R4 base5", region_base[5*32 +: 32], 32'h4000_0000);
        chk("R4 base3 untouched", region_base[3*32 +: 32], 32'h2000_12E0);
        do_read(6'h00, 32'd5, "R4 sel=5");
        do_read(6'h04, 32'h4000_0005, "R4 base5 read");
        do_write(6'h04, 32'h5000_0019);
        chk("R4 bad num base5", region_base[5*32 +: 32], 32'h4000_0000);
        chk("R4 bad num base1", region_base[1*32 +: 32], 32'h0);
        do_read(6'h00, 32'd5, "R4 bad num sel kept");

        // R2 three-word burst from selector
        do_write(6'h00, 32'd2);
        do_write(6'h04, 32'h6000_0000);
        do_write(6'h08, 32'h0000_0101);
        chk("R2 burst base2", region_base[2*32 +: 32], 32'h6000_0000);
        chk("R2 burst srd2", {24'b0, region_srd[2*8 +: 8]}, 32'h01);

        // R7 alias burst programming four regions
        do_write(6'h0C, 32'h7000_0010);
        do_write(6'h10, 32'h00FF_0003);
        do_write(6'h14, 32'h7100_0011);
        do_write(6'h18, 32'h0022_0005);
        do_write(6'h1C, 32'h7200_0016);
        do_write(6'h20, 32'h0033_FF07);
        do_write(6'h04, 32'h7300_0017);
        do_write(6'h08, 32'h0044_0F09);
        chk("R7 base0", region_base[0 +: 32], 32'h7000_0000);
        chk("R7 base1", region_base[32 +: 32], 32'h7100_0000);
        chk("R7 base6", region_base[6*32 +: 32], 32'h7200_0000);
        chk("R7 base7", region_base[7*32 +: 32], 32'h7300_0000);
        chk("R7 attr0", {16'b0, region_attr[0 +: 16]}, 32'h00FF);
        chk("R7 size1", {27'b0, region_size[1*5 +: 5]}, 32'd2);
        chk("R7 srd6", {24'b0, region_srd[6*8 +: 8]}, 32'hFF);
        do_read(6'h00, 32'd7, "R7 sel=7");
        do_read(6'h0C, 32'h7300_0007, "R7 alias base read");
        do_read(6'h20, 32'h0044_0F09, "R7 alias attr read");

        // R5 read-modify-write disable
        do_read(6'h08, 32'h0044_0F09, "R5 rmw read");
        do_write(6'h08, 32'h0044_0F08);
        chk("R5 rmw en7", {31'b0, region_en[7]}, 32'h0);
        chk("R5 rmw size7", {27'b0, region_size[7*5 +: 5]}, 32'd4);
        chk("R5 rmw srd7", {24'b0, region_srd[7*8 +: 8]}, 32'h0F);
        chk("R5 rmw attr7", {16'b0, region_attr[7*16 +: 16]}, 32'h44);

        // R8 unmapped offsets
        do_write(6'h24, 32'hFFFF_FFFF);
        do_write(6'h3C, 32'hFFFF_FFFF);
        chk("R8 unmapped en", {24'b0, region_en}, 32'h4F);
        chk("R8 unmapped base7", region_base[7*32 +: 32], 32'h7300_0000);
        do_read(6'h00, 32'd7, "R8 unmapped sel kept");
        do_read(6'h24, 32'h0, "R8 unmapped read");
        do_read(6'h3C, 32'h0, "R8 unmapped read high");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL R8 actual=%0d missing reads expected=0", exp_q.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule